// File: doc/BRIEF.md
# Register-bank bus slave with programmable wait states

This block is one slave on a single-master AHB-Lite bus that holds a small bank of 32-bit registers. Address and control are taken in the address phase. The transfer then completes in the data phase that follows, so the next address can be presented while the current data moves. A configuration input sets how many wait states each real transfer gets. During those cycles the slave holds its ready output low, which also holds off the next address phase.

Only NONSEQ and SEQ transfers reach the registers. IDLE and BUSY cycles complete at once with an OKAY response. Writes update only the byte lanes selected by the transfer size and the low address bits, in little-endian lane order. An access to a word beyond the bank, or a size wider than the bus, gets a two-cycle error response and changes nothing. Bursts need no special handling: each beat is decoded as its own transfer.

Top module: `ahbl_wait_regs`

## Requirements
- R1: After reset, hreadyOut is 1 and hresp is 0, and every register reads back as zero.
- R2: A cycle with hsel low, or with htrans equal to 00 (IDLE) or 01 (BUSY), starts no access. The next cycle shows hreadyOut 1 and hresp 0, and no register changes.
- R3: A cycle with hsel 1, hreadyIn 1 and htrans 10 (NONSEQ) or 11 (SEQ) is an address phase. Its data phase starts in the next cycle. Write data is taken from hwdata in the last data-phase cycle. A new address phase may overlap that cycle, so a read placed right after a write returns the written value.
- R4: waitCfg is sampled in the address phase. With a value of N, hreadyOut is 0 for the first N cycles of the data phase and 1 in the cycle after them, and hresp stays 0 throughout.
- R5: On a read, hrdata carries the whole addressed 32-bit register in the data-phase cycle where hreadyOut is 1.
- R6: While hreadyIn is 0, the slave takes no address phase. A request presented only in such a cycle is dropped, and hreadyOut stays 1 with hresp 0 in the next cycle.
- R7: hsize 000 writes the one byte lane at address bits [1:0]. hsize 001 writes the two lanes picked by address bit 1. hsize 010 writes all four lanes. Lane k is hwdata bits [8k+7:8k].
- R8: An access is in error if its word index, taken from address bits [7:2], is not below the register count (4), or if hsize is above 010. An error response has one cycle with hresp 1 and hreadyOut 0, then one cycle with hresp 1 and hreadyOut 1. No register is written.
- R9: hwrite 1 selects a write and 0 a read. A read leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 8 | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size |
| hwdata | input | 32 | Write data (data phase) |
| hreadyIn | input | 1 | Bus-wide ready; an address phase counts only when high |
| waitCfg | input | 3 | Wait states per real transfer |
| hrdata | output | 32 | Read data |
| hreadyOut | output | 1 | Slave ready; low inserts a wait state |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |

## Verification
The bench sweeps every register, every size and every byte offset. It varies the wait count and alternates NONSEQ with SEQ, so a lane mask that is shifted or too wide corrupts a read-back. It places a read right after a write, both with and without wait states. A slave that takes the next address during a stall, or reads before the write lands, then returns stale data or gives the wrong sequence of ready cycles. Requests during IDLE, BUSY and a low hreadyIn carry write data that must not land. Out-of-range and oversize accesses must give exactly one low-ready error cycle and leave the registers as they were.

// File: rtl/ahbl_pkg.sv
package ahbl_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACC,
    PH_ERR1,
    PH_ERR2
  } phase_e;

  typedef struct packed {
    logic capture;
    logic doWrite;
    logic doRead;
  } strobe_t;
endpackage

// File: rtl/ahbl_ctrl.sv
module ahbl_ctrl
  import ahbl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int WAIT_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsel,
  input  logic [1:0]        htrans,
  input  logic              hreadyIn,
  input  logic [ADDR_W-3:0] wordIdx,
  input  logic [2:0]        hsize,
  input  logic              hwrite,
  input  logic [WAIT_W-1:0] waitCfg,
  output strobe_t           strb,
  output logic              hreadyOut,
  output logic              hresp
);
  phase_e            phase, phaseNext;
  logic [WAIT_W-1:0] cnt, cntNext;
  logic              writeQ;
  logic              active, bad, done;

  always_comb begin
    active = hsel && hreadyIn && htrans[1];
    bad    = (32'(wordIdx) >= NUM_REGS) || (hsize > 3'd2);
    done   = (phase == PH_ACC) && (cnt == '0);
  end

  always_comb begin
    hreadyOut = (phase == PH_ACC) ? (cnt == '0) : (phase != PH_ERR1);
    hresp     = (phase == PH_ERR1) || (phase == PH_ERR2);
  end

  always_comb begin
    phaseNext = PH_IDLE;
    cntNext   = cnt;
    if ((phase == PH_ACC) && (cnt != '0)) begin
      phaseNext = PH_ACC;
      cntNext   = cnt - 1'b1;
    end else if (phase == PH_ERR1) begin
      phaseNext = PH_ERR2;
    end else if (active && bad) begin
      phaseNext = PH_ERR1;
    end else if (active) begin
      phaseNext = PH_ACC;
      cntNext   = waitCfg;
    end
  end

  always_comb begin
    strb.capture = active && !bad && hreadyOut;
    strb.doWrite = done && writeQ;
    strb.doRead  = done && !writeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      writeQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
      if (strb.capture) writeQ <= hwrite;
    end
  end

  assert_idle_ok_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hsel && hreadyIn && !htrans[1] && hreadyOut) |=> (hreadyOut && !hresp));

  assert_wait_okay_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!hreadyOut && !hresp) |=> !hresp);

  assert_err_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hresp && !hreadyOut) |=> (hresp && hreadyOut));

  assert_err_first_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hresp) |-> !hreadyOut);
endmodule

// File: rtl/ahbl_regfile.sv
module ahbl_regfile
  import ahbl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        hsize,
  input  logic [31:0]       hwdata,
  output logic [31:0]       hrdata
);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [SEL_W-1:0]              idxQ;
  logic [1:0]                    offQ;
  logic [1:0]                    sizeQ;
  logic [3:0]                    laneEn;
  logic [NUM_REGS-1:0][31:0]     regBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      offQ  <= '0;
      sizeQ <= '0;
    end else if (strb.capture) begin
      idxQ  <= haddr[2 +: SEL_W];
      offQ  <= haddr[1:0];
      sizeQ <= hsize;
    end
  end

  always_comb begin
    case (sizeQ)
      2'd0:    laneEn = 4'b0001 << offQ;
      2'd1:    laneEn = offQ[1] ? 4'b1100 : 4'b0011;
      default: laneEn = 4'b1111;
    endcase
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [31:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (strb.doWrite && (32'(idxQ) == r)) begin
        for (int b = 0; b < 4; b++) begin
          if (laneEn[b]) q[8*b +: 8] <= hwdata[8*b +: 8];
        end
      end
    end
    assign regBus[r] = q;
  end

  always_comb hrdata = strb.doRead ? regBus[idxQ] : '0;

  assert_read_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRead |=> $stable(regBus));
endmodule

// File: rtl/ahbl_wait_regs.sv
module ahbl_wait_regs
  import ahbl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int WAIT_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [31:0]       hwdata,
  input  logic              hreadyIn,
  input  logic [WAIT_W-1:0] waitCfg,
  output logic [31:0]       hrdata,
  output logic              hreadyOut,
  output logic              hresp
);
  strobe_t strb;

  ahbl_ctrl #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .WAIT_W(WAIT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .hsel(hsel), .htrans(htrans), .hreadyIn(hreadyIn),
    .wordIdx(haddr[ADDR_W-1:2]), .hsize(hsize), .hwrite(hwrite),
    .waitCfg(waitCfg), .strb(strb), .hreadyOut(hreadyOut), .hresp(hresp)
  );

  ahbl_regfile #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .haddr(haddr), .hsize(hsize[1:0]),
    .hwdata(hwdata), .hrdata(hrdata)
  );
endmodule

// File: tb/ahbl_wait_regs_tb_top.sv
module ahbl_wait_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hsel = 1'b0;
  logic [7:0]  haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'd2;
  logic [31:0] hwdata = '0;
  logic [2:0]  waitCfg = '0;
  logic        holdOff = 1'b0;
  logic        hreadyIn;
  logic [31:0] hrdata;
  logic        hreadyOut, hresp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] model [4];

  always #10 clk = ~clk;
  assign hreadyIn = hreadyOut && !holdOff;

  ahbl_wait_regs dut_i (
    .clk(clk), .rstN(rstN), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hreadyIn(hreadyIn),
    .waitCfg(waitCfg), .hrdata(hrdata), .hreadyOut(hreadyOut), .hresp(hresp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input int sz, input int off);
    logic [31:0] m;
    if (sz == 0) m = 32'hFF << (8 * off);
    else if (sz == 1) m = 32'hFFFF << (16 * (off / 2));
    else m = 32'hFFFF_FFFF;
    return (old & ~m) | (d & m);
  endfunction

  task automatic xfer(input logic wr, input logic [7:0] addr, input logic [2:0] sz,
                      input logic [31:0] data, input int waits, input logic [1:0] tr,
                      input logic expErr, input string req);
    int low;
    @(negedge clk);
    hsel = 1'b1; htrans = tr; hwrite = wr; haddr = addr; hsize = sz; waitCfg = 3'(waits);
    @(posedge clk);
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwdata = data;
    #1;
    low = 0;
    while (!hreadyOut && low < 20) begin
      chk(hresp == expErr, {req, " resp during stall"}, 32'(hresp), 32'(expErr));
      low++;
      @(negedge clk); #1;
    end
    chk(low == (expErr ? 1 : waits), {req, " stall cycles"}, 32'(low), 32'(expErr ? 1 : waits));
    chk(hresp == expErr, {req, " resp at completion"}, 32'(hresp), 32'(expErr));
    if (!wr && !expErr)
      chk(hrdata == model[addr[3:2]], {req, " read data"}, hrdata, model[addr[3:2]]);
    if (wr && !expErr)
      model[addr[3:2]] = merge(model[addr[3:2]], data, int'(sz), int'(addr[1:0]));
  endtask

  task automatic readAll(input string req);
    for (int r = 0; r < 4; r++) xfer(1'b0, 8'(r * 4), 3'd2, 32'h0, r % 3, 2'b10, 1'b0, req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 4; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(hreadyOut == 1'b1, "R1 ready after reset", 32'(hreadyOut), 32'd1);
    chk(hresp == 1'b0, "R1 okay after reset", 32'(hresp), 32'd0);
    readAll("R1 reset value");

    // R7 R9 R4 R5 sweep of registers, sizes, offsets, wait counts
    for (int r = 0; r < 4; r++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++) begin
          logic [31:0] d;
          d = 32'h9E37_79B9 * 32'(r * 12 + sz * 4 + off + 1);
          xfer(1'b1, 8'(r * 4 + off), 3'(sz), d, (r + sz + off) % 4,
               ((off % 2) == 1) ? 2'b11 : 2'b10, 1'b0, "R7 lane write");
          xfer(1'b0, 8'(r * 4), 3'd2, 32'h0, (off + 1) % 4, 2'b11, 1'b0, "R5 R9 read back");
        end
    readAll("R9 reads keep contents");

    // R2 IDLE and BUSY carry no access
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      hsel = 1'b1; htrans = 2'(t); hwrite = 1'b1; haddr = 8'h00; hsize = 3'd2; waitCfg = 3'd3;
      @(posedge clk);
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b00; hwdata = 32'hFFFF_FFFF;
      #1;
      chk(hreadyOut == 1'b1, "R2 no stall on idle/busy", 32'(hreadyOut), 32'd1);
      chk(hresp == 1'b0, "R2 okay on idle/busy", 32'(hresp), 32'd0);
    end
    // R2 hsel low with NONSEQ
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b10; hwrite = 1'b1; haddr = 8'h04; waitCfg = 3'd2;
    @(posedge clk);
    @(negedge clk);
    htrans = 2'b00; hwdata = 32'hFFFF_FFFF;
    #1;
    chk(hreadyOut == 1'b1, "R2 unselected no stall", 32'(hreadyOut), 32'd1);
    readAll("R2 no write landed");

    // R6 request while hreadyIn low is dropped
    @(negedge clk);
    holdOff = 1'b1; hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 8'h0C; hsize = 3'd2; waitCfg = 3'd2;
    @(posedge clk);
    @(negedge clk);
    holdOff = 1'b0; hsel = 1'b0; htrans = 2'b00; hwdata = 32'hDEAD_BEEF;
    #1;
    chk(hreadyOut == 1'b1, "R6 no stall after held request", 32'(hreadyOut), 32'd1);
    chk(hresp == 1'b0, "R6 okay after held request", 32'(hresp), 32'd0);
    xfer(1'b0, 8'h0C, 3'd2, 32'h0, 0, 2'b10, 1'b0, "R6 held write dropped");

    // R3 back-to-back write then read, no wait states
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 8'h04; hsize = 3'd2; waitCfg = 3'd0;
    @(posedge clk);
    @(negedge clk);
    hwdata = 32'hC0FF_EE01; hwrite = 1'b0; htrans = 2'b10; haddr = 8'h04;
    #1;
    chk(hreadyOut == 1'b1, "R3 write completes at once", 32'(hreadyOut), 32'd1);
    @(posedge clk);
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00;
    #1;
    model[1] = 32'hC0FF_EE01;
    chk(hreadyOut == 1'b1, "R3 read ready", 32'(hreadyOut), 32'd1);
    chk(hrdata == 32'hC0FF_EE01, "R3 pipelined read sees write", hrdata, 32'hC0FF_EE01);

    // R3 R4 back-to-back with two wait states each
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 8'h08; hsize = 3'd2; waitCfg = 3'd2;
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      logic expR;
      @(negedge clk);
      if (i == 0) begin
        hwdata = 32'h5A5A_1234; hwrite = 1'b0; htrans = 2'b10; haddr = 8'h08;
      end
      if (i == 3) begin
        hsel = 1'b0; htrans = 2'b00;
      end
      #1;
      expR = (i == 2) || (i == 5);
      chk(hreadyOut == expR, "R4 ready pattern over two stalled transfers", 32'(hreadyOut), 32'(expR));
      chk(hresp == 1'b0, "R4 okay while stalled", 32'(hresp), 32'd0);
      if (i == 5) chk(hrdata == 32'h5A5A_1234, "R3 read after stalled write", hrdata, 32'h5A5A_1234);
    end
    model[2] = 32'h5A5A_1234;

    // R8 errors: out-of-range words and oversize transfers
    xfer(1'b1, 8'h10, 3'd2, 32'h1111_1111, 2, 2'b10, 1'b1, "R8 word 4 write");
    xfer(1'b1, 8'h3C, 3'd0, 32'h2222_2222, 0, 2'b11, 1'b1, "R8 word 15 write");
    xfer(1'b0, 8'hFC, 3'd2, 32'h0, 3, 2'b10, 1'b1, "R8 word 63 read");
    xfer(1'b1, 8'h04, 3'd3, 32'h3333_3333, 1, 2'b10, 1'b1, "R8 oversize write");
    xfer(1'b1, 8'h00, 3'd7, 32'h4444_4444, 0, 2'b10, 1'b1, "R8 size 7 write");
    readAll("R8 no write on error");
    xfer(1'b1, 8'h00, 3'd2, 32'h7777_8888, 1, 2'b10, 1'b0, "R8 recovery write");
    xfer(1'b0, 8'h00, 3'd2, 32'h0, 0, 2'b10, 1'b0, "R8 recovery read");

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule